// File: doc/BRIEF.md
# Conditional Branch-to-Link Unit

This unit resolves one conditional return-style branch each time `issue_i` is raised. The branch target is the address held in the link register. Two tests decide the outcome. The first is an optional step of the count register followed by a zero test on that stepped count. The second compares one chosen bit of the 32-bit condition register with a sense bit. Four option bits arrive with the instruction and control both tests. A further input can ask the unit to write the link register with the return address at the same time.

The result is registered one clock after issue. It gives the next instruction address, the new count value, the new link value and a taken flag. `done_o` marks the cycle in which that result is valid. A small two-state sequencer controls the timing. In `ST_IDLE`, no result is being presented. In `ST_RESOLVED`, a fresh result is on the outputs. The sequencer follows four transitions:

- `ST_IDLE` goes to `ST_RESOLVED` when an instruction is issued.
- `ST_RESOLVED` stays in `ST_RESOLVED` when another instruction is issued back to back.
- `ST_RESOLVED` returns to `ST_IDLE` when no instruction is issued.
- `ST_IDLE` stays in `ST_IDLE` when nothing is issued.

Bit numbering follows the machine convention in which bit 0 is the most significant bit. The count is tested over all 64 bits in wide mode. In narrow mode, only its low 32 bits (machine bits 32..63) are tested.

Top module: `bclr_unit`

## Requirements
- R1: While `rst_n` is low, `npc_o`, `cnt_o`, `lnk_o`, `taken_o` and `done_o` are all zero.
- R2: An issue raises `done_o` on the next clock edge and loads a new result. A cycle without issue drops `done_o` at the next edge and leaves every data output unchanged.
- R3: If `opt_i[1]` (skip count) is 1, `cnt_o` becomes `cnt_i` unchanged. If it is 0, `cnt_o` becomes `cnt_i` minus one modulo 2^64, so zero wraps to all ones.
- R4: If `opt_i[1]` is 1, the count test passes. Otherwise it passes when "stepped count non-zero" XOR `opt_i[0]` (count sense) is 1. The stepped count is examined over all 64 bits when `wide_i` is 1, and over bits [31:0] only when `wide_i` is 0.
- R5: If `opt_i[3]` (ignore condition) is 1, the condition test passes. Otherwise it passes when `cond_reg_i[31 - crsel_i]` equals `opt_i[2]` (condition sense), so a selector of 0 picks `cond_reg_i[31]`.
- R6: `taken_o` is 1 exactly when both tests pass. When taken, `npc_o` is the incoming `lnk_i` with bits [1:0] forced to 0. This value is taken before any link write of the same instruction.
- R7: When not taken, `npc_o` is `pc_i` plus 4.
- R8: If `link_i` is 1, `lnk_o` becomes `pc_i` plus 4, whether or not the branch is taken. If `link_i` is 0, `lnk_o` becomes `lnk_i`.
- R9: Instructions issued on consecutive cycles each produce their own correct result in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | One instruction is presented this cycle |
| opt_i | input | 4 | Options: [3] ignore condition, [2] condition sense, [1] skip count, [0] count sense |
| crsel_i | input | 5 | Condition bit selector, 0 = most significant bit |
| link_i | input | 1 | Write return address to link register |
| wide_i | input | 1 | 1 = test the full 64-bit count, 0 = test the low 32 bits |
| pc_i | input | 64 | Current instruction address |
| cond_reg_i | input | 32 | Condition register |
| cnt_i | input | 64 | Current count register |
| lnk_i | input | 64 | Current link register |
| npc_o | output | 64 | Next instruction address |
| cnt_o | output | 64 | Updated count register |
| lnk_o | output | 64 | Updated link register |
| taken_o | output | 1 | Branch was taken |
| done_o | output | 1 | Outputs hold the result of the previous cycle's issue |

## Verification
The link write and the target read can fall in the same instruction. If they do, the target must come from the link value before the write, while the link output takes the return address. The sweep provokes this with every option pattern and with `link_i` both set and clear. The link value has non-zero low bits, so a target drawn from the wrong source or left unmasked differs from the expected value. The count step and the zero test also share a cycle. Counts of 0, 1 and a value whose low half only becomes zero after the step are judged against a bench-computed result in both width modes.

// File: rtl/bclr_pkg.sv
package bclr_pkg;

    // Sequencer states
    typedef enum logic [0:0] {
        ST_IDLE     = 1'b0,
        ST_RESOLVED = 1'b1
    } bclr_state_t;

    // Option field as decoded from the instruction (MSB first)
    typedef struct packed {
        logic ign_cond;    // [3] condition test always passes
        logic cond_sense;  // [2] required value of the chosen condition bit
        logic skip_cnt;    // [1] count is not stepped and its test passes
        logic cnt_sense;   // [0] inverts the non-zero result of the count test
    } bclr_opt_t;

    localparam int unsigned OPT_W = $bits(bclr_opt_t);

endpackage

// File: rtl/bclr_count.sv
// Count step and zero test.
module bclr_count #(
    parameter int unsigned XLEN     = 64,
    parameter int unsigned NARROW_W = 32
) (
    input  logic [XLEN-1:0] cnt_i,
    input  logic            skip_i,
    input  logic            sense_i,
    input  logic            wide_i,
    output logic [XLEN-1:0] cnt_next_o,
    output logic            ok_o
);
    localparam logic [XLEN-1:0] ONE = XLEN'(1);

    logic lo_nz;
    logic hi_nz;
    logic tested_nz;

    always_comb begin
        cnt_next_o = skip_i ? cnt_i : (cnt_i - ONE);
    end

    assign lo_nz = |cnt_next_o[NARROW_W-1:0];

    generate
        if (NARROW_W < XLEN) begin : g_split
            assign hi_nz = |cnt_next_o[XLEN-1:NARROW_W];
        end else begin : g_flat
            assign hi_nz = 1'b0;
        end
    endgenerate

    always_comb begin
        tested_nz = lo_nz | (wide_i & hi_nz);
        ok_o      = skip_i | (tested_nz ^ sense_i);
    end

endmodule

// File: rtl/bclr_cond.sv
// Condition-bit selection and compare.
module bclr_cond #(
    parameter int unsigned CR_W  = 32,
    parameter int unsigned SEL_W = $clog2(CR_W)
) (
    input  logic [CR_W-1:0]  cond_reg_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             ignore_i,
    input  logic             sense_i,
    output logic             ok_o
);
    // Reversed view: index 0 is the most significant condition bit
    logic [CR_W-1:0] msb_first;
    logic            picked;

    generate
        for (genvar g = 0; g < CR_W; g++) begin : g_rev
            assign msb_first[g] = cond_reg_i[CR_W-1-g];
        end
    endgenerate

    always_comb begin
        picked = msb_first[sel_i];
        ok_o   = ignore_i | (picked == sense_i);
    end

endmodule

// File: rtl/bclr_target.sv
// Next-address and link update.
module bclr_target #(
    parameter int unsigned XLEN       = 64,
    parameter int unsigned STEP       = 4,
    parameter int unsigned ALIGN_BITS = 2
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] lnk_i,
    input  logic            taken_i,
    input  logic            link_i,
    output logic [XLEN-1:0] npc_o,
    output logic [XLEN-1:0] lnk_next_o
);
    localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] target;

    always_comb begin
        seq_pc     = pc_i + STEP_V;
        // target is taken from the link value before any write
        target     = {lnk_i[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        npc_o      = taken_i ? target : seq_pc;
        lnk_next_o = link_i ? seq_pc : lnk_i;
    end

endmodule

// File: rtl/bclr_unit.sv
module bclr_unit
    import bclr_pkg::*;
#(
    parameter int unsigned XLEN     = 64,
    parameter int unsigned CR_W     = 32,
    parameter int unsigned NARROW_W = XLEN / 2,
    parameter int unsigned STEP     = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     issue_i,
    input  logic [3:0]               opt_i,
    input  logic [$clog2(CR_W)-1:0]  crsel_i,
    input  logic                     link_i,
    input  logic                     wide_i,
    input  logic [XLEN-1:0]          pc_i,
    input  logic [CR_W-1:0]          cond_reg_i,
    input  logic [XLEN-1:0]          cnt_i,
    input  logic [XLEN-1:0]          lnk_i,
    output logic [XLEN-1:0]          npc_o,
    output logic [XLEN-1:0]          cnt_o,
    output logic [XLEN-1:0]          lnk_o,
    output logic                     taken_o,
    output logic                     done_o
);
    localparam int unsigned SEL_W = $clog2(CR_W);

    bclr_opt_t       opt;
    bclr_state_t     state_q;
    bclr_state_t     state_d;

    logic            cnt_ok;
    logic            cond_ok;
    logic            taken_c;
    logic [XLEN-1:0] cnt_next;
    logic [XLEN-1:0] npc_next;
    logic [XLEN-1:0] lnk_next;

    assign opt = bclr_opt_t'(opt_i);

    bclr_count #(
        .XLEN     (XLEN),
        .NARROW_W (NARROW_W)
    ) i_count (
        .cnt_i      (cnt_i),
        .skip_i     (opt.skip_cnt),
        .sense_i    (opt.cnt_sense),
        .wide_i     (wide_i),
        .cnt_next_o (cnt_next),
        .ok_o       (cnt_ok)
    );

    bclr_cond #(
        .CR_W  (CR_W),
        .SEL_W (SEL_W)
    ) i_cond (
        .cond_reg_i (cond_reg_i),
        .sel_i      (crsel_i),
        .ignore_i   (opt.ign_cond),
        .sense_i    (opt.cond_sense),
        .ok_o       (cond_ok)
    );

    assign taken_c = cnt_ok & cond_ok;

    bclr_target #(
        .XLEN       (XLEN),
        .STEP       (STEP),
        .ALIGN_BITS (2)
    ) i_target (
        .pc_i       (pc_i),
        .lnk_i      (lnk_i),
        .taken_i    (taken_c),
        .link_i     (link_i),
        .npc_o      (npc_next),
        .lnk_next_o (lnk_next)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     state_d = issue_i ? ST_RESOLVED : ST_IDLE;
            ST_RESOLVED: state_d = issue_i ? ST_RESOLVED : ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result registers: loaded only when an instruction is issued
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            npc_o   <= '0;
            cnt_o   <= '0;
            lnk_o   <= '0;
            taken_o <= 1'b0;
        end else if (issue_i) begin
            npc_o   <= npc_next;
            cnt_o   <= cnt_next;
            lnk_o   <= lnk_next;
            taken_o <= taken_c;
        end
    end

    // Output decode from state
    always_comb begin
        unique case (state_q)
            ST_IDLE:     done_o = 1'b0;
            ST_RESOLVED: done_o = 1'b1;
            default:     done_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bclr_unit_chk.sv
module bclr_unit_chk #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned CR_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    issue_i,
    input logic [3:0]              opt_i,
    input logic                    link_i,
    input logic [XLEN-1:0]         pc_i,
    input logic [XLEN-1:0]         cnt_i,
    input logic [XLEN-1:0]         npc_o,
    input logic [XLEN-1:0]         cnt_o,
    input logic [XLEN-1:0]         lnk_o,
    input logic                    taken_o,
    input logic                    done_o
);
    localparam logic [XLEN-1:0] FOUR = XLEN'(4);
    localparam logic [XLEN-1:0] ONE  = XLEN'(1);

    // R2
    done_follows_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> done_o);

    // R2
    done_drops_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> !done_o);

    // R2
    outputs_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> ($stable(npc_o) && $stable(cnt_o) && $stable(lnk_o) && $stable(taken_o)));

    // R3
    count_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && opt_i[1]) |=> (cnt_o == $past(cnt_i)));

    // R3
    count_stepped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !opt_i[1]) |=> (cnt_o == $past(cnt_i) - ONE));

    // R6
    always_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && opt_i[3] && opt_i[1]) |=> taken_o);

    // R6
    target_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && taken_o) |-> (npc_o[1:0] == 2'b00));

    // R7
    fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> (taken_o || (npc_o == $past(pc_i) + FOUR)));

    // R8
    link_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && link_i) |=> (lnk_o == $past(pc_i) + FOUR));

endmodule

bind bclr_unit bclr_unit_chk #(
    .XLEN (XLEN),
    .CR_W (CR_W)
) i_bclr_unit_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue_i (issue_i),
    .opt_i   (opt_i),
    .link_i  (link_i),
    .pc_i    (pc_i),
    .cnt_i   (cnt_i),
    .npc_o   (npc_o),
    .cnt_o   (cnt_o),
    .lnk_o   (lnk_o),
    .taken_o (taken_o),
    .done_o  (done_o)
);

// File: tb/test_bclr_unit.sv
`timescale 1ns/1ps
module test_bclr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [3:0]  opt_i = '0;
    logic [4:0]  crsel_i = '0;
    logic        link_i = 1'b0;
    logic        wide_i = 1'b0;
    logic [63:0] pc_i = '0;
    logic [31:0] cond_reg_i = '0;
    logic [63:0] cnt_i = '0;
    logic [63:0] lnk_i = '0;
    logic [63:0] npc_o;
    logic [63:0] cnt_o;
    logic [63:0] lnk_o;
    logic        taken_o;
    logic        done_o;

    int total = 0;
    int bad   = 0;

    logic        pending = 1'b0;
    logic [63:0] e_npc = '0;
    logic [63:0] e_cnt = '0;
    logic [63:0] e_lnk = '0;
    logic        e_taken = 1'b0;
    logic        e_done = 1'b0;

    always #2.5 clk = ~clk;

    bclr_unit i_bclr_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_i    (issue_i),
        .opt_i      (opt_i),
        .crsel_i    (crsel_i),
        .link_i     (link_i),
        .wide_i     (wide_i),
        .pc_i       (pc_i),
        .cond_reg_i (cond_reg_i),
        .cnt_i      (cnt_i),
        .lnk_i      (lnk_i),
        .npc_o      (npc_o),
        .cnt_o      (cnt_o),
        .lnk_o      (lnk_o),
        .taken_o    (taken_o),
        .done_o     (done_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_pending();
        if (pending) begin
            check("R2/R9 done", {63'd0, done_o}, {63'd0, e_done});
            check("R4 R5 R6 taken", {63'd0, taken_o}, {63'd0, e_taken});
            check("R6 R7 npc", npc_o, e_npc);
            check("R3 cnt", cnt_o, e_cnt);
            check("R8 lnk", lnk_o, e_lnk);
        end
    endtask

    // One cycle: judge the previous cycle's result, then drive this cycle
    task automatic step(input logic v, input logic [3:0] o, input logic [4:0] s,
                        input logic lk, input logic w, input logic [63:0] pc,
                        input logic [31:0] cr, input logic [63:0] c, input logic [63:0] l);
        logic [63:0] nc;
        logic [63:0] tested;
        logic        c_ok;
        logic        k_ok;
        @(negedge clk);
        compare_pending();
        issue_i    = v;
        opt_i      = o;
        crsel_i    = s;
        link_i     = lk;
        wide_i     = w;
        pc_i       = pc;
        cond_reg_i = cr;
        cnt_i      = c;
        lnk_i      = l;
        e_done     = v;
        if (v) begin
            nc      = o[1] ? c : c - 64'd1;
            tested  = w ? nc : {32'd0, nc[31:0]};
            c_ok    = o[1] | ((tested != 64'd0) ^ o[0]);
            k_ok    = o[3] | (cr[31 - s] == o[2]);
            e_taken = c_ok & k_ok;
            e_npc   = e_taken ? {l[63:2], 2'b00} : pc + 64'd4;
            e_cnt   = nc;
            e_lnk   = lk ? pc + 64'd4 : l;
        end
        pending = 1'b1;
    endtask

    initial begin
        #100000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] cvals [6];
        logic [4:0]  svals [3];
        cvals[0] = 64'd0;                    // R3 wraps to all ones
        cvals[1] = 64'd1;                    // stepped count becomes zero
        cvals[2] = 64'd2;
        cvals[3] = 64'h0000_0001_0000_0001;  // R4 low half zero after step
        cvals[4] = 64'h0000_0001_0000_0000;
        cvals[5] = 64'h8000_0000_0000_0000;
        svals[0] = 5'd0;                     // R5 selects cond_reg_i[31]
        svals[1] = 5'd13;
        svals[2] = 5'd31;

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 npc", npc_o, 64'd0);
        check("R1 cnt", cnt_o, 64'd0);
        check("R1 lnk", lnk_o, 64'd0);
        check("R1 taken", {63'd0, taken_o}, 64'd0);
        check("R1 done", {63'd0, done_o}, 64'd0);
        rst_n = 1'b1;
        pending = 1'b1;

        // R2 idle cycles after reset keep outputs at zero
        step(1'b0, 4'd0, 5'd0, 1'b0, 1'b0, 64'd0, 32'd0, 64'd0, 64'd0);
        step(1'b0, 4'd0, 5'd0, 1'b0, 1'b0, 64'd0, 32'd0, 64'd0, 64'd0);

        // Sweep of every option pattern, both width modes, link on/off (R9 back to back)
        for (int o = 0; o < 16; o++) begin
            for (int w = 0; w < 2; w++) begin
                for (int lk = 0; lk < 2; lk++) begin
                    for (int ci = 0; ci < 6; ci++) begin
                        for (int si = 0; si < 3; si++) begin
                            step(1'b1, 4'(o), svals[si], 1'(lk), 1'(w),
                                 64'h0000_0000_0040_1000 + 64'(ci * 16 + si * 4),
                                 ci[0] ? 32'h8004_0001 : 32'h7FFB_FFFE,
                                 cvals[ci],
                                 64'hFFFF_0000_1234_567B ^ 64'(o << 8));
                        end
                    end
                    // R2 idle gap: outputs hold, done drops
                    step(1'b0, 4'hF, 5'd7, 1'b1, 1'b1, 64'hDEAD, 32'hFFFF_FFFF,
                         64'h55, 64'h77);
                end
            end
        end

        step(1'b0, 4'd0, 5'd0, 1'b0, 1'b0, 64'd0, 32'd0, 64'd0, 64'd0);
        @(negedge clk);
        compare_pending();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule